// File: doc/BRIEF.md
# Receive Character Queue with Interrupt Sources

This block is the receive-side buffer of a memory-mapped serial port. A deserializer presents each received character, together with its break, parity-error and framing-error flags, on a valid/ready push stream. The block stores up to `DEPTH` such entries in order. Software takes them out one at a time by reading the data register. When the queue is already full, an incoming character is discarded and a sticky overrun flag is raised. Only a queue reset command clears that flag.

Three interrupt causes are tracked: overrun, a fill level above a programmable threshold, and data left untouched for a programmable number of character times. The character-time strobe comes from the baud logic outside the block. Each cause has a mask bit and a status bit in the interrupt register, and the single interrupt pin is the OR of the masked causes. A not-empty bit in the same register lets a driver drain the queue until that bit reads 0.

The push stream has a simple back-pressure rule. `push_ready` equals the receive-enable bit and does not depend on the fill level. A producer that cannot stall therefore never waits. While enabled, every character offered is taken: it is either stored or counted as an overrun drop. While disabled, nothing is taken.

Top module: `rxq_buffer`

## Requirements
- R1: After reset the queue is empty, the enable, threshold, timeout and mask fields are 0, `irq` is 0 and `push_ready` is 0.
- R2: Reading address 2 while the queue holds data returns the oldest entry and removes it. Bits 7:0 carry the character, bit 8 is a valid flag equal to 1, bit 9 is break, bit 10 is parity error and bit 11 is framing error. Entries leave in the order they arrived.
- R3: Reading address 2 while the queue is empty returns 0 and changes nothing.
- R4: A push taken while the queue holds `DEPTH` entries, with no pop in the same cycle, is discarded and sets the overrun status, which is bit 8 of the interrupt register at address 1. Popping entries does not clear this status.
- R5: Writing the control register at address 0 with bit 1 set empties the queue and clears the overrun status. Bit 1 always reads back as 0. A push offered in the same cycle is discarded without setting overrun.
- R6: Bit 0 of the control register is the receive enable. `push_ready` equals this bit. While it is 0, offered characters are not stored.
- R7: The threshold status (interrupt register bit 9) is 1 exactly when the fill level is greater than control bits 6:2.
- R8: The timeout status (interrupt register bit 10) is 1 when all three of these hold: the queue is non-empty, control bits 10:7 are non-zero, and the count of `char_tick` pulses seen since the last taken push, pop or reset is at least that value. A value of 0 disables the timeout.
- R9: Interrupt register bit 11 reads 1 exactly when the queue is non-empty.
- R10: Interrupt register bits 2:0 are read/write mask bits for overrun, threshold and timeout, in that order. `irq` is the OR of each status bit ANDed with its mask bit, so writing 0 to the interrupt register silences `irq`.
- R11: Writes to address 2, and writes to the status bits of the interrupt register, have no effect on the stored data or on any status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | A received character is offered |
| push_ready | output | 1 | Character is taken this cycle (equals receive enable) |
| push_char | input | 8 | Received character |
| push_brk | input | 1 | Break detected on this character |
| push_par | input | 1 | Parity error on this character |
| push_frm | input | 1 | Framing error on this character |
| char_tick | input | 1 | One-cycle strobe per character time |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 2 pops) |
| reg_addr | input | 2 | Register address: 0 control, 1 interrupt, 2 data |
| reg_wdata | input | 11 | Register write data |
| reg_rdata | output | 12 | Register read data, valid in the cycle of the read |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is the timeout status. It needs data to sit in the queue with no push and no pop while enough character strobes arrive. Random traffic keeps restarting the idle count, so the stimulus includes a directed phase that stores a few entries, stops all traffic and issues strobes one by one, reading the interrupt register on every cycle. A second directed phase overfills the queue, then drains it completely to show that overrun survives the drain and clears only on a queue reset. The random phase then mixes pushes, pops on empty and full queues, threshold changes, resets and strobes against a cycle-level model.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic       frm;
    logic       par;
    logic       brk;
    logic [7:0] ch;
  } rxq_entry_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_IRQ  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int CAUSE_OVR = 0;
  localparam int CAUSE_THR = 1;
  localparam int CAUSE_TMO = 2;
  localparam int N_CAUSE   = 3;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          put,
  input  logic          take,
  input  rxq_entry_t    put_entry,
  output rxq_entry_t    head,
  output logic [CW-1:0] level
);
  rxq_entry_t mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (put) mem[wp] <= put_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (put)  wp <= bump(wp);
      if (take) rp <= bump(rp);
      case ({put, take})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign head = mem[rp];

  // R4: a store never happens into a full queue without a pop
  p_put_has_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (put && !take) |-> (level < CW'(DEPTH)));
  // R3: a pop never happens on an empty queue
  p_take_not_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (level != '0));
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int TMO_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             holding,
  input  logic             tick,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] idle;

  always_ff @(posedge clk) begin
    if (!rst_n || restart)
      idle <= '0;
    else if (holding && tick && idle != '1)
      idle <= idle + 1'b1;
  end

  assign expired = holding && (limit != '0) && (idle >= limit);

  // R8: timeout status only with data present
  p_expire_needs_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> holding);
  // R8: any push, pop or reset restarts the idle window
  p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !expired);
endmodule

// File: rtl/rxq_irq_unit.sv
module rxq_irq_unit
  import rxq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               drop,
  input  logic               level_hit,
  input  logic               expired,
  input  logic               mask_we,
  input  logic [N_CAUSE-1:0] mask_wdata,
  output logic [N_CAUSE-1:0] mask,
  output logic [N_CAUSE-1:0] status,
  output logic               irq
);
  logic ovr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr  <= 1'b0;
      mask <= '0;
    end else begin
      if (flush)     ovr <= 1'b0;
      else if (drop) ovr <= 1'b1;
      if (mask_we) mask <= mask_wdata;
    end
  end

  always_comb begin
    status            = '0;
    status[CAUSE_OVR] = ovr;
    status[CAUSE_THR] = level_hit;
    status[CAUSE_TMO] = expired;
  end

  assign irq = |(status & mask);

  // R4: overrun is sticky until a queue reset
  p_overrun_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !flush) |=> ovr);
  // R4: overrun rises only after a dropped character
  p_overrun_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(drop));
  // R10: an all-zero mask keeps the pin low
  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TMO_W = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int WD_W = 2 + CW + TMO_W,
  localparam int RD_W = (WD_W > 12) ? WD_W : 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_valid,
  output logic            push_ready,
  input  logic [7:0]      push_char,
  input  logic            push_brk,
  input  logic            push_par,
  input  logic            push_frm,
  input  logic            char_tick,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [1:0]      reg_addr,
  input  logic [WD_W-1:0] reg_wdata,
  output logic [RD_W-1:0] reg_rdata,
  output logic            irq
);
  logic             rx_en;
  logic [CW-1:0]    thr_q;
  logic [TMO_W-1:0] tmo_q;
  logic [CW-1:0]    level;
  rxq_entry_t       head, in_entry;
  logic [N_CAUSE-1:0] mask, status;
  logic flush, push_acc, pop, full, put, drop, holding, expired;

  assign push_ready = rx_en;
  assign push_acc   = push_valid && rx_en;
  assign flush      = reg_wr && (reg_addr == ADDR_CTRL) && reg_wdata[1];
  assign holding    = (level != '0);
  assign full       = (level == CW'(DEPTH));
  assign pop        = reg_rd && (reg_addr == ADDR_DATA) && holding;
  assign put        = push_acc && !flush && (!full || pop);
  assign drop       = push_acc && !flush && full && !pop;
  assign in_entry   = '{frm: push_frm, par: push_par, brk: push_brk, ch: push_char};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en <= 1'b0;
      thr_q <= '0;
      tmo_q <= '0;
    end else if (reg_wr && reg_addr == ADDR_CTRL) begin
      rx_en <= reg_wdata[0];
      thr_q <= reg_wdata[2 +: CW];
      tmo_q <= reg_wdata[2 + CW +: TMO_W];
    end
  end

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .put(put), .take(pop),
    .put_entry(in_entry), .head(head), .level(level)
  );

  rxq_idle_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(push_acc || pop || flush),
    .holding(holding), .tick(char_tick), .limit(tmo_q), .expired(expired)
  );

  rxq_irq_unit u_irq (
    .clk(clk), .rst_n(rst_n), .flush(flush), .drop(drop),
    .level_hit(level > thr_q), .expired(expired),
    .mask_we(reg_wr && reg_addr == ADDR_IRQ),
    .mask_wdata(reg_wdata[N_CAUSE-1:0]),
    .mask(mask), .status(status), .irq(irq)
  );

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = RD_W'({tmo_q, thr_q, 1'b0, rx_en});
      ADDR_IRQ:  reg_rdata = RD_W'({holding, status, 5'b0, mask});
      ADDR_DATA: reg_rdata = holding ?
                   RD_W'({head.frm, head.par, head.brk, 1'b1, head.ch}) : '0;
      default:   reg_rdata = '0;
    endcase
  end

  // R6: with receive disabled and no register traffic, the level holds
  p_disabled_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_ready && !pop && !flush) |=> $stable(level));
  // R5: a queue reset leaves the queue empty on the next cycle
  p_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));
  // R2: a pop with no store lowers the level by one
  p_pop_lowers_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !put) |=> (level == $past(level) - 1'b1));
endmodule

// File: tb/rxq_buffer_test.sv
module rxq_buffer_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        push_valid, push_brk, push_par, push_frm, char_tick;
  logic [7:0]  push_char;
  logic        reg_wr, reg_rd;
  logic [1:0]  reg_addr;
  logic [10:0] reg_wdata;
  logic [11:0] reg_rdata;
  logic        push_ready, irq;

  rxq_buffer uut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
    .push_char(push_char), .push_brk(push_brk), .push_par(push_par),
    .push_frm(push_frm), .char_tick(char_tick), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  int checks = 0;
  int errors = 0;

  logic [10:0] mq[$];
  bit          m_ov, m_en;
  logic [2:0]  m_mask;
  int          m_thr, m_tmo, m_idle;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_thr();
    return mq.size() > m_thr;
  endfunction

  function automatic bit exp_tmo();
    return (mq.size() != 0) && (m_tmo != 0) && (m_idle >= m_tmo);
  endfunction

  function automatic logic [10:0] ctrl_word(input bit en, input bit fl,
                                            input int thr, input int tmo);
    return {4'(tmo), 5'(thr), fl, en};
  endfunction

  task automatic idle_inputs();
    push_valid = 0; push_char = 0; push_brk = 0; push_par = 0; push_frm = 0;
    char_tick = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
  endtask

  task automatic check_outputs();
    logic [2:0] st;
    st = {exp_tmo(), exp_thr(), m_ov};
    chk("R6 push_ready", push_ready, m_en);
    chk("R10 irq pin", irq, |(st & m_mask));
    if (reg_rd) begin
      case (reg_addr)
        2'd0: chk("R5 control readback", reg_rdata, {1'b0, 4'(m_tmo), 5'(m_thr), 1'b0, m_en});
        2'd1: begin
          chk("R4 overrun status", reg_rdata[8], m_ov);
          chk("R7 threshold status", reg_rdata[9], exp_thr());
          chk("R8 timeout status", reg_rdata[10], exp_tmo());
          chk("R9 not-empty", reg_rdata[11], mq.size() != 0);
          chk("R10 mask readback", reg_rdata[2:0], m_mask);
        end
        2'd2: begin
          if (mq.size() != 0)
            chk("R2 data entry", reg_rdata, {mq[0][10:8], 1'b1, mq[0][7:0]});
          else
            chk("R3 empty read", reg_rdata, 0);
        end
        default: ;
      endcase
    end
  endtask

  task automatic update_model();
    bit fl, pop, pacc;
    int pre;
    pre  = mq.size();
    fl   = reg_wr && reg_addr == 2'd0 && reg_wdata[1];
    pop  = reg_rd && reg_addr == 2'd2 && pre != 0;
    pacc = push_valid && m_en;
    if (fl) begin
      mq.delete(); m_ov = 0; m_idle = 0;
    end else begin
      if (pop) void'(mq.pop_front());
      if (pacc) begin
        if (pre == 16 && !pop) m_ov = 1;
        else mq.push_back({push_frm, push_par, push_brk, push_char});
      end
      if (pop || pacc) m_idle = 0;
      else if (pre != 0 && char_tick && m_idle != 15) m_idle++;
    end
    if (reg_wr && reg_addr == 2'd0) begin
      m_en = reg_wdata[0]; m_thr = reg_wdata[6:2]; m_tmo = reg_wdata[10:7];
    end
    if (reg_wr && reg_addr == 2'd1) m_mask = reg_wdata[2:0];
  endtask

  // check, clock edge, model step, then return at the falling edge
  task automatic step();
    #1;
    check_outputs();
    @(posedge clk);
    update_model();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [10:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; step();
  endtask

  task automatic rd_reg(input logic [1:0] a);
    reg_rd = 1; reg_addr = a; step();
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_inputs();
    m_ov = 0; m_en = 0; m_mask = 0; m_thr = 0; m_tmo = 0; m_idle = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 irq after reset", irq, 0);
    chk("R1 push_ready after reset", push_ready, 0);
    reg_rd = 1; reg_addr = 2'd1; #1;
    chk("R1 interrupt register after reset", reg_rdata, 0);
    step();
    rd_reg(2'd0);

    // R6: pushes offered while disabled are not stored
    push_valid = 1; push_char = 8'h5A; step();
    push_valid = 1; push_char = 8'h5B; reg_rd = 1; reg_addr = 2'd1; #1;
    chk("R6 disabled push ignored", reg_rdata[11], 0);
    step();

    // enable, threshold 8, timeout off, unmask all
    wr_reg(2'd0, ctrl_word(1, 0, 8, 0));
    wr_reg(2'd1, 11'h7);

    // R4: fill to depth, then one more
    for (int i = 0; i < 17; i++) begin
      push_valid = 1; push_char = 8'(8'h30 + i);
      push_brk = i[0]; push_par = i[1]; push_frm = i[2];
      step();
    end
    rd_reg(2'd1);
    for (int i = 0; i < 16; i++) rd_reg(2'd2);
    reg_rd = 1; reg_addr = 2'd1; #1;
    chk("R4 overrun survives drain", reg_rdata[8], 1);
    step();
    rd_reg(2'd2);

    // R11: writes to data and status bits are ignored
    push_valid = 1; push_char = 8'hC3; step();
    wr_reg(2'd2, 11'h7FF);
    wr_reg(2'd1, 11'h7F8);
    reg_rd = 1; reg_addr = 2'd1; #1;
    chk("R11 status after ignored writes", reg_rdata[11:8], 4'b1001);
    step();
    wr_reg(2'd1, 11'h7);

    // R5: queue reset clears overrun and data, and a push in the same cycle is dropped
    push_valid = 1; push_char = 8'hEE;
    reg_wr = 1; reg_addr = 2'd0; reg_wdata = ctrl_word(1, 1, 8, 0); step();
    reg_rd = 1; reg_addr = 2'd1; #1;
    chk("R5 reset clears queue and overrun", reg_rdata[11:8], 4'b0000);
    step();
    rd_reg(2'd0);

    // R8: timeout of 2 character times with data waiting
    wr_reg(2'd0, ctrl_word(1, 0, 15, 2));
    push_valid = 1; push_char = 8'h11; step();
    push_valid = 1; push_char = 8'h22; step();
    for (int i = 0; i < 4; i++) begin
      char_tick = 1; reg_rd = 1; reg_addr = 2'd1; step();
    end
    rd_reg(2'd1);
    rd_reg(2'd2);
    rd_reg(2'd1);
    for (int i = 0; i < 3; i++) begin
      char_tick = 1; step();
    end
    rd_reg(2'd1);
    rd_reg(2'd2);
    rd_reg(2'd1);
    wr_reg(2'd1, 11'h0);
    rd_reg(2'd1);

    // mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      push_valid = ($urandom % 100) < 45;
      push_char  = 8'($urandom);
      push_brk   = ($urandom % 8) == 0;
      push_par   = ($urandom % 8) == 0;
      push_frm   = ($urandom % 8) == 0;
      char_tick  = ($urandom % 4) == 0;
      r = $urandom % 100;
      if (r < 30)      begin reg_rd = 1; reg_addr = 2'd2; end
      else if (r < 40) begin reg_rd = 1; reg_addr = 2'd1; end
      else if (r < 44) begin reg_rd = 1; reg_addr = 2'd0; end
      else if (r < 47) begin
        reg_wr = 1; reg_addr = 2'd0;
        reg_wdata = ctrl_word(($urandom % 10) != 0, ($urandom % 8) == 0,
                              $urandom % 17, $urandom % 4);
      end
      else if (r < 49) begin reg_wr = 1; reg_addr = 2'd1; reg_wdata = 11'($urandom); end
      else if (r < 50) begin reg_wr = 1; reg_addr = 2'd2; reg_wdata = 11'($urandom); end
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule